// File: doc/BRIEF.md
# Bit-Serial Authenticated Stream Cipher Core

This block is a bit-serial authenticated stream cipher engine built from a 128-bit linear register, a 128-bit nonlinear register, a nonlinear filter that yields one pre-output bit per round, and a 64-bit tag datapath. The tag datapath is a 64-bit shift register plus a 64-bit accumulator. A one-cycle `start` pulse captures a 128-bit key and a 96-bit nonce. The core then runs a fixed schedule on its own. First come 320 mixing rounds and 64 key re-injection rounds. Then 128 rounds preload the accumulator and the shift register. After that the core raises `msg_ready`.

In keystream mode each accepted message bit uses two rounds. The even round's pre-output bit is XORed onto the message bit and returned as a registered ciphertext bit. The odd round's bit enters the tag datapath. While `msg_valid` is low the core holds its whole state, so the caller sets the pace. The accumulator is visible on `tag` at all times. The caller appends its own final padding bit as an ordinary message bit and reads `tag` once that bit's odd round has completed.

The nonlinear feedback is evaluated over two cycles. Its product terms are computed one round ahead from the register contents as they will be after the current shift, and are held in a register. The same is done for the filter's product terms. Only the linear taps are evaluated in the round that uses them. This costs one lead-in cycle after loading, and the produced bit sequence is the same as that of the unsplit shift-register form.

Top module: `gr_aead_core`

## Requirements
- R1: On the clock edge that samples `start` high, nonlinear register bit i takes `key[i]` for i = 0..127. Linear register bits 0..95 take `iv[0..95]`, bits 96..126 become 1 and bit 127 becomes 0.
- R2: The edge after loading is a lead-in with no shift. Each of the next 320 edges shifts both registers toward bit 0, with the pre-output bit XORed into the new bit 127 of both registers.
- R3: In the following 64 rounds (round index t = 320..383) there is no pre-output feedback. `key[t-320]` is XORed into the nonlinear register's new bit and `key[t-256]` into the linear register's new bit.
- R4: The next 64 pre-output bits fill the accumulator and the 64 after them fill the shift register. In both, the first bit lands in bit 0 and the last in bit 63. `tag` shows the accumulator, and `msg_ready` rises exactly 513 edges after the edge that sampled `start`.
- R5: When `msg_ready` and `msg_valid` are both high at an edge, the message bit is accepted. After that edge `ct_valid` is high for one cycle with `ct_bit` = message bit XOR the even-round pre-output bit, and `msg_ready` is low for exactly one cycle.
- R6: On the odd round after an accepted bit equal to 1, the accumulator is XORed with the shift register's value before the shift. On every odd round the shift register then moves toward bit 0 and takes the odd pre-output bit into bit 63.
- R7: `msg_valid` has no effect while `msg_ready` is low. While `msg_ready` is high and `msg_valid` is low, neither register shifts, `tag` holds and no ciphertext is produced.
- R8: The ciphertext sequence and the tag equal those of the unsplit single-cycle feedback form for any key, nonce and message.
- R9: During and right after synchronous reset, `msg_ready` and `ct_valid` are 0 and `tag` is all zero.
- R10: A `start` pulse in any phase, including partway through initialization, discards the run in progress and starts again from R1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Load key and nonce and begin initialization |
| key | input | 128 | Secret key, bit i is key bit i |
| iv | input | 96 | Nonce, bit i is nonce bit i |
| msg_valid | input | 1 | A message bit is offered |
| msg_bit | input | 1 | Message bit |
| msg_ready | output | 1 | Core can accept a message bit this cycle |
| ct_valid | output | 1 | One-cycle pulse, `ct_bit` is valid |
| ct_bit | output | 1 | Ciphertext bit |
| tag | output | 64 | Current accumulator value |

## Verification
The hardest situation to reach from the ports is the look-ahead register being reused after a round with no shift: the lead-in cycle, and idle cycles in keystream mode. In both cases the precomputed terms must describe the unshifted state. The bench drives this by holding `msg_valid` low for several cycles in the middle of a message and then checking that the following ciphertext bits and the final tag still match an independent bit-at-a-time reference model. It also restarts the core partway through mixing, and it holds `msg_valid` high throughout initialization to show that it is ignored.

// File: rtl/gr_pkg.sv
package gr_pkg;
  localparam int FSR_W         = 128;
  localparam int KEY_W         = 128;
  localparam int IV_W          = 96;
  localparam int ACC_W         = 64;
  localparam int MIX_ROUNDS    = 320;
  localparam int KEYMIX_ROUNDS = 64;
  localparam int INIT_ROUNDS   = MIX_ROUNDS + KEYMIX_ROUNDS;
  localparam int FILL_ROUNDS   = 2 * ACC_W;
  localparam int CNT_W         = $clog2(INIT_ROUNDS);
  localparam int KIDX_W        = $clog2(KEYMIX_ROUNDS);

  typedef enum logic [1:0] {INJ_NONE, INJ_PREOUT, INJ_KEY} inj_e;
  typedef enum logic [2:0] {PH_IDLE, PH_LEAD, PH_INIT, PH_FILL, PH_KS} phase_e;

  // Product terms of the nonlinear feedback (highest index read: 95)
  function automatic logic nl_products(input logic [FSR_W-1:0] b);
    return (b[3] & b[67]) ^ (b[11] & b[13]) ^ (b[17] & b[18]) ^
           (b[27] & b[59]) ^ (b[40] & b[48]) ^ (b[61] & b[65]) ^
           (b[68] & b[84]) ^ (b[22] & b[24] & b[25]) ^
           (b[70] & b[78] & b[82]) ^ (b[88] & b[92] & b[93] & b[95]);
  endfunction

  // Linear part of the nonlinear feedback, evaluated in the round itself
  function automatic logic nl_linear(input logic [FSR_W-1:0] b,
                                     input logic [FSR_W-1:0] s);
    return s[0] ^ b[0] ^ b[26] ^ b[56] ^ b[91] ^ b[96];
  endfunction

  function automatic logic lin_feedback(input logic [FSR_W-1:0] s);
    return s[0] ^ s[7] ^ s[38] ^ s[70] ^ s[81] ^ s[96];
  endfunction

  // Product terms of the filter (highest index read: b95, s94)
  function automatic logic filt_products(input logic [FSR_W-1:0] b,
                                         input logic [FSR_W-1:0] s);
    return (b[12] & s[8]) ^ (s[13] & s[20]) ^ (b[95] & s[42]) ^
           (s[60] & s[79]) ^ (b[12] & b[95] & s[94]);
  endfunction

  function automatic logic filt_linear(input logic [FSR_W-1:0] b,
                                       input logic [FSR_W-1:0] s);
    return s[93] ^ b[2] ^ b[15] ^ b[36] ^ b[45] ^ b[64] ^ b[73] ^ b[89];
  endfunction
endpackage

// File: rtl/gr_seq.sv
module gr_seq
  import gr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              msg_valid,
  output logic              load,
  output logic              adv,
  output inj_e              inj_sel,
  output logic [KIDX_W-1:0] kidx,
  output logic              fill_acc,
  output logic              fill_sr,
  output logic              accept,
  output logic              odd_step,
  output logic              msg_ready
);
  localparam logic [CNT_W-1:0] MIX_N   = CNT_W'(MIX_ROUNDS);
  localparam logic [CNT_W-1:0] INIT_LST = CNT_W'(INIT_ROUNDS - 1);
  localparam logic [CNT_W-1:0] FILL_LST = CNT_W'(FILL_ROUNDS - 1);
  localparam logic [CNT_W-1:0] ACC_N   = CNT_W'(ACC_W);

  phase_e           ph_q;
  logic [CNT_W-1:0] cnt_q;
  logic             odd_q;
  logic [CNT_W-1:0] kofs;

  assign kofs      = cnt_q - MIX_N;
  assign kidx      = kofs[KIDX_W-1:0];
  assign load      = start;
  assign msg_ready = (ph_q == PH_KS) && !odd_q;
  assign accept    = msg_ready && msg_valid && !start;
  assign odd_step  = (ph_q == PH_KS) && odd_q && !start;
  assign fill_acc  = !start && (ph_q == PH_FILL) && (cnt_q < ACC_N);
  assign fill_sr   = !start && (ph_q == PH_FILL) && (cnt_q >= ACC_N);

  always_comb begin
    adv = 1'b0;
    if (!start) begin
      unique case (ph_q)
        PH_INIT, PH_FILL: adv = 1'b1;
        PH_KS:            adv = odd_q || msg_valid;
        default:          adv = 1'b0;
      endcase
    end
  end

  always_comb begin
    inj_sel = INJ_NONE;
    if (ph_q == PH_INIT)
      inj_sel = (cnt_q < MIX_N) ? INJ_PREOUT : INJ_KEY;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
      odd_q <= 1'b0;
    end else if (start) begin
      ph_q  <= PH_LEAD;
      cnt_q <= '0;
      odd_q <= 1'b0;
    end else begin
      unique case (ph_q)
        PH_LEAD: begin
          ph_q  <= PH_INIT;
          cnt_q <= '0;
        end
        PH_INIT: begin
          if (cnt_q == INIT_LST) begin
            ph_q  <= PH_FILL;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        PH_FILL: begin
          if (cnt_q == FILL_LST) begin
            ph_q  <= PH_KS;
            cnt_q <= '0;
            odd_q <= 1'b0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        PH_KS: begin
          if (odd_q)       odd_q <= 1'b0;
          else if (accept) odd_q <= 1'b1;
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/gr_fsr_core.sv
module gr_fsr_core
  import gr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              adv,
  input  inj_e              inj_sel,
  input  logic [KIDX_W-1:0] kidx,
  input  logic [KEY_W-1:0]  key,
  input  logic [IV_W-1:0]   iv,
  output logic              preout,
  output logic [FSR_W-1:0]  nfsr_q,
  output logic [FSR_W-1:0]  lfsr_q
);
  localparam int PAD_W = FSR_W - IV_W;
  localparam logic [PAD_W-1:0] PAD = {1'b0, {(PAD_W-1){1'b1}}};

  logic [KEY_W-1:0] key_q;
  logic             gprod_q;   // look-ahead register, nonlinear feedback
  logic             hprod_q;   // look-ahead register, filter
  logic             g_full, f_full, inj_b, inj_s, fb_b, fb_s;
  logic [FSR_W-1:0] b_view, s_view;

  assign preout = hprod_q ^ filt_linear(nfsr_q, lfsr_q);
  assign g_full = gprod_q ^ nl_linear(nfsr_q, lfsr_q);
  assign f_full = lin_feedback(lfsr_q);

  always_comb begin
    unique case (inj_sel)
      INJ_PREOUT: begin inj_b = preout;            inj_s = preout;            end
      INJ_KEY:    begin inj_b = key_q[{1'b0, kidx}]; inj_s = key_q[{1'b1, kidx}]; end
      default:    begin inj_b = 1'b0;              inj_s = 1'b0;              end
    endcase
  end

  assign fb_b = g_full ^ inj_b;
  assign fb_s = f_full ^ inj_s;

  // State as it will be after this edge; bit 127 is never read by product terms
  assign b_view = adv ? {1'b0, nfsr_q[FSR_W-1:1]} : nfsr_q;
  assign s_view = adv ? {1'b0, lfsr_q[FSR_W-1:1]} : lfsr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      nfsr_q  <= '0;
      lfsr_q  <= '0;
      key_q   <= '0;
      gprod_q <= 1'b0;
      hprod_q <= 1'b0;
    end else if (load) begin
      nfsr_q  <= key;
      lfsr_q  <= {PAD, iv};
      key_q   <= key;
      gprod_q <= 1'b0;
      hprod_q <= 1'b0;
    end else begin
      if (adv) begin
        nfsr_q <= {fb_b, nfsr_q[FSR_W-1:1]};
        lfsr_q <= {fb_s, lfsr_q[FSR_W-1:1]};
      end
      gprod_q <= nl_products(b_view);
      hprod_q <= filt_products(b_view, s_view);
    end
  end
endmodule

// File: rtl/gr_auth.sv
module gr_auth
  import gr_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             fill_acc,
  input  logic             fill_sr,
  input  logic             take,
  input  logic             m_in,
  input  logic             upd,
  input  logic             y,
  output logic [ACC_W-1:0] acc_q
);
  logic [ACC_W-1:0] sr_q;
  logic             m_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      acc_q <= '0;
      sr_q  <= '0;
      m_q   <= 1'b0;
    end else begin
      if (fill_acc) acc_q <= {y, acc_q[ACC_W-1:1]};
      if (fill_sr)  sr_q  <= {y, sr_q[ACC_W-1:1]};
      if (take)     m_q   <= m_in;
      if (upd) begin
        if (m_q) acc_q <= acc_q ^ sr_q;
        sr_q <= {y, sr_q[ACC_W-1:1]};
      end
    end
  end
endmodule

// File: rtl/gr_aead_core.sv
module gr_aead_core
  import gr_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [KEY_W-1:0] key,
  input  logic [IV_W-1:0]  iv,
  input  logic             msg_valid,
  input  logic             msg_bit,
  output logic             msg_ready,
  output logic             ct_valid,
  output logic             ct_bit,
  output logic [ACC_W-1:0] tag
);
  logic              load, adv, fill_acc, fill_sr, accept, odd_step, y;
  inj_e              inj_sel;
  logic [KIDX_W-1:0] kidx;
  logic [FSR_W-1:0]  nfsr_st, lfsr_st;

  gr_seq u_seq (
    .clk(clk), .rst(rst), .start(start), .msg_valid(msg_valid),
    .load(load), .adv(adv), .inj_sel(inj_sel), .kidx(kidx),
    .fill_acc(fill_acc), .fill_sr(fill_sr), .accept(accept),
    .odd_step(odd_step), .msg_ready(msg_ready)
  );

  gr_fsr_core u_fsr (
    .clk(clk), .rst(rst), .load(load), .adv(adv), .inj_sel(inj_sel),
    .kidx(kidx), .key(key), .iv(iv), .preout(y),
    .nfsr_q(nfsr_st), .lfsr_q(lfsr_st)
  );

  gr_auth u_auth (
    .clk(clk), .rst(rst), .clr(load), .fill_acc(fill_acc),
    .fill_sr(fill_sr), .take(accept), .m_in(msg_bit), .upd(odd_step),
    .y(y), .acc_q(tag)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ct_valid <= 1'b0;
      ct_bit   <= 1'b0;
    end else begin
      ct_valid <= accept;
      if (accept) ct_bit <= msg_bit ^ y;
    end
  end
endmodule

// File: rtl/gr_aead_core_chk.sv
module gr_aead_core_chk (
  input logic         clk,
  input logic         rst,
  input logic         start,
  input logic [127:0] key,
  input logic [95:0]  iv,
  input logic         msg_valid,
  input logic         msg_ready,
  input logic         ct_valid,
  input logic [63:0]  tag,
  input logic [127:0] nfsr_st,
  input logic [127:0] lfsr_st
);
  p_load_nfsr_r1: assert property (@(posedge clk) disable iff (rst)
    start |=> nfsr_st == $past(key));

  p_load_lfsr_r1: assert property (@(posedge clk) disable iff (rst)
    start |=> lfsr_st == {1'b0, {31{1'b1}}, $past(iv)});

  p_lead_hold_r2: assert property (@(posedge clk) disable iff (rst)
    ($past(start) && !start) |=> ($stable(nfsr_st) && $stable(lfsr_st)));

  p_accept_ct_r5: assert property (@(posedge clk) disable iff (rst)
    (msg_ready && msg_valid && !start) |=> (ct_valid && !msg_ready));

  p_ct_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    ct_valid |=> !ct_valid);

  p_no_ct_r7: assert property (@(posedge clk) disable iff (rst)
    !msg_ready |=> !ct_valid);

  p_stall_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (msg_ready && !msg_valid && !start) |=>
      ($stable(tag) && $stable(lfsr_st) && $stable(nfsr_st) && msg_ready));
endmodule

bind gr_aead_core gr_aead_core_chk u_chk (
  .clk(clk), .rst(rst), .start(start), .key(key), .iv(iv),
  .msg_valid(msg_valid), .msg_ready(msg_ready), .ct_valid(ct_valid),
  .tag(tag), .nfsr_st(nfsr_st), .lfsr_st(lfsr_st)
);

// File: tb/gr_aead_core_test.sv
module gr_aead_core_test;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [127:0] key = '0;
  logic [95:0]  iv = '0;
  logic         msg_valid = 1'b0;
  logic         msg_bit = 1'b0;
  logic         msg_ready, ct_valid, ct_bit;
  logic [63:0]  tag;

  int n_checks = 0;
  int n_errors = 0;

  // reference model state (single-cycle feedback form)
  logic [127:0] rb, rs;
  logic [63:0]  racc, rsr;

  always #5 clk = ~clk;

  gr_aead_core uut (
    .clk(clk), .rst(rst), .start(start), .key(key), .iv(iv),
    .msg_valid(msg_valid), .msg_bit(msg_bit), .msg_ready(msg_ready),
    .ct_valid(ct_valid), .ct_bit(ct_bit), .tag(tag)
  );

  task automatic check(input bit ok, input string what, input logic [127:0] act,
                       input logic [127:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  function automatic logic ref_y(input logic [127:0] b, input logic [127:0] s);
    return (b[12] & s[8]) ^ (s[13] & s[20]) ^ (b[95] & s[42]) ^ (s[60] & s[79]) ^
           (b[12] & b[95] & s[94]) ^ s[93] ^ b[2] ^ b[15] ^ b[36] ^ b[45] ^
           b[64] ^ b[73] ^ b[89];
  endfunction

  function automatic logic ref_g(input logic [127:0] b, input logic [127:0] s);
    return s[0] ^ b[0] ^ b[26] ^ b[56] ^ b[91] ^ b[96] ^ (b[3] & b[67]) ^
           (b[11] & b[13]) ^ (b[17] & b[18]) ^ (b[27] & b[59]) ^ (b[40] & b[48]) ^
           (b[61] & b[65]) ^ (b[68] & b[84]) ^ (b[22] & b[24] & b[25]) ^
           (b[70] & b[78] & b[82]) ^ (b[88] & b[92] & b[93] & b[95]);
  endfunction

  function automatic logic ref_f(input logic [127:0] s);
    return s[0] ^ s[7] ^ s[38] ^ s[70] ^ s[81] ^ s[96];
  endfunction

  task automatic ref_round(input logic inj_b, input logic inj_s, output logic y);
    logic gv, fv;
    y  = ref_y(rb, rs);
    gv = ref_g(rb, rs) ^ inj_b;
    fv = ref_f(rs) ^ inj_s;
    rb = {gv, rb[127:1]};
    rs = {fv, rs[127:1]};
  endtask

  task automatic ref_init(input logic [127:0] k, input logic [95:0] n);
    logic y;
    rb = k;
    rs = {1'b0, {31{1'b1}}, n};
    for (int t = 0; t < 384; t++) begin
      y = ref_y(rb, rs);
      if (t < 320) ref_round(y, y, y);
      else         ref_round(k[t-320], k[t-256], y);
    end
    for (int i = 0; i < 64; i++) begin ref_round(1'b0, 1'b0, y); racc = {y, racc[63:1]}; end
    for (int i = 0; i < 64; i++) begin ref_round(1'b0, 1'b0, y); rsr  = {y, rsr[63:1]};  end
  endtask

  task automatic ref_msg(input logic m, output logic ct);
    logic y0, y1;
    ref_round(1'b0, 1'b0, y0);
    ct = m ^ y0;
    ref_round(1'b0, 1'b0, y1);
    if (m) racc = racc ^ rsr;
    rsr = {y1, rsr[63:1]};
  endtask

  // Pulses start and waits for msg_ready; reports latency and stray ciphertext
  task automatic launch(input logic [127:0] k, input logic [95:0] n,
                        output int lat, output bit stray);
    @(negedge clk);
    key = k; iv = n; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    lat = 0; stray = 1'b0;
    while (!msg_ready && lat < 2000) begin
      @(posedge clk); #1;
      lat++;
      if (ct_valid) stray = 1'b1;
    end
  endtask

  task automatic send_bit(input logic m, input string rq);
    logic exp_ct;
    ref_msg(m, exp_ct);
    @(negedge clk);
    msg_valid = 1'b1; msg_bit = m;
    @(posedge clk); #1;
    check(ct_valid === 1'b1 && ct_bit === exp_ct, {rq, " ciphertext bit"},
          {ct_valid, ct_bit}, {1'b1, exp_ct});
    check(msg_ready === 1'b0, "R5 ready low on odd round", msg_ready, 0);
    @(negedge clk);
    msg_valid = 1'b0;
    @(posedge clk); #1;
    check(msg_ready === 1'b1 && ct_valid === 1'b0, "R5 ready back after odd round",
          {msg_ready, ct_valid}, 2'b10);
  endtask

  task automatic send_word(input logic [31:0] w, input int len, input string rq);
    for (int i = 0; i < len; i++) send_bit(w[i], rq);
  endtask

  task automatic t_reset;
    repeat (3) @(posedge clk);
    #1;
    check(msg_ready === 1'b0 && ct_valid === 1'b0 && tag === 64'h0,
          "R9 outputs during reset", {msg_ready, ct_valid, tag}, 0);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;
    check(msg_ready === 1'b0 && ct_valid === 1'b0 && tag === 64'h0,
          "R9 outputs after reset", {msg_ready, ct_valid, tag}, 0);
  endtask

  task automatic t_vector_a;
    int lat; bit stray;
    logic [127:0] k = 128'h0f1e2d3c4b5a69788796a5b4c3d2e1f0;
    logic [95:0]  n = 96'hdeadbeef0123456789abcdef;
    ref_init(k, n);
    launch(k, n, lat, stray);
    check(lat == 513, "R4 ready latency (R2 lead-in, R3 key rounds)", lat, 513);
    check(tag === racc, "R4 accumulator after fill (R1 R2 R3 R8)", tag, racc);
    send_word(32'hA5C3_0F71, 24, "R5 R8 vector A");
    send_bit(1'b1, "R5 padding bit");
    #1;
    check(tag === racc, "R6 tag after message A", tag, racc);
  endtask

  task automatic t_vector_zero;
    int lat; bit stray;
    ref_init('0, '0);
    launch('0, '0, lat, stray);
    check(tag === racc, "R4 accumulator after fill, zero key", tag, racc);
    send_word(32'hFFFF_FFFF, 10, "R8 all-ones message");
    check(tag === racc, "R6 tag after all-ones message", tag, racc);
  endtask

  task automatic t_stall;
    int lat; bit stray;
    logic [63:0] held;
    logic [127:0] k = 128'h3141592653589793238462643383279f;
    logic [95:0]  n = 96'h271828182845904523536028;
    ref_init(k, n);
    launch(k, n, lat, stray);
    send_word(32'h0000_0006, 4, "R8 before stall");
    held = tag;
    for (int i = 0; i < 6; i++) begin
      @(posedge clk); #1;
      check(ct_valid === 1'b0 && msg_ready === 1'b1 && tag === held,
            "R7 idle holds state", {ct_valid, msg_ready, tag}, {2'b01, held});
    end
    send_word(32'h0000_00B5, 8, "R7 R8 after stall");
    check(tag === racc, "R7 tag after stalled message", tag, racc);
  endtask

  task automatic t_ignore_valid;
    int lat; bit stray;
    logic [127:0] k = 128'hffeeddccbbaa99887766554433221100;
    logic [95:0]  n = 96'h000000000000000000000001;
    ref_init(k, n);
    @(negedge clk); msg_valid = 1'b1; msg_bit = 1'b1;
    launch(k, n, lat, stray);
    msg_valid = 1'b0;
    check(stray == 1'b0, "R7 no ciphertext while not ready", stray, 0);
    check(lat == 513 && tag === racc, "R7 init unaffected by msg_valid",
          {lat[15:0], tag}, {16'd513, racc});
    send_word(32'h0000_0003, 3, "R7 first bits after ignored valid");
  endtask

  task automatic t_restart;
    int lat; bit stray;
    logic [127:0] k = 128'h00000000000000000000000000000080;
    logic [95:0]  n = 96'h800000000000000000000000;
    @(negedge clk);
    key = ~k; iv = ~n; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (200) @(posedge clk);
    ref_init(k, n);
    launch(k, n, lat, stray);
    check(lat == 513, "R10 restart latency", lat, 513);
    check(tag === racc, "R10 accumulator after restart", tag, racc);
    send_word(32'h0000_0159, 9, "R10 ciphertext after restart");
    check(tag === racc, "R10 tag after restart", tag, racc);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    t_reset();
    t_vector_a();
    t_vector_zero();
    t_stall();
    t_ignore_valid();
    t_restart();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule